// File: doc/BRIEF.md
# SIMD Lane Request Coalescer

This block sits between a 16-lane SIMD issue stage and the memory controller. One group of lanes hands over its load or store addresses as a burst of beats, four lanes per beat, over four accepted beats. Once the last beat is in, the block merges the requests into the fewest aligned memory transactions its rules allow. It hands each transaction out on a valid/ready channel as a byte base address, a byte size and a mask of the lanes that transaction serves.

Lane addresses are word-aligned byte addresses, and a word is 4 bytes. Transactions are 32, 64, 128 or 256 bytes long and aligned to their own size. A lane that sits on its own next to a large aligned window is served by a separate one-word (4-byte) transaction, so the large window does not have to grow to twice its size. Lanes whose active flag is clear play no part in the group. After the last transaction of a group is accepted, a one-cycle done pulse marks the end of the group. Only then is the next group's first beat taken.

Top module: `simd_coalescer`

## Requirements
- R1: On each accepted beat (`in_valid` and `in_ready` both high), the block takes four lanes. Beat b, position p, fills lane 4*b+p, with the address in bits [32*p+31:32*p] of `in_addr` and the active flag in bit p of `in_active`. `in_ready` is high only while a group is being gathered. It stays low from the fourth accepted beat until the group has finished emitting.
- R2: After reset, `in_ready` is 1, `out_valid` is 0 and `group_done` is 0.
- R3: An inactive lane never appears in any `out_mask`, and its address has no influence on any transaction. If a group has no active lane, it emits no transaction and pulses `group_done` in the cycle after its fourth beat is accepted.
- R4: Sixteen active lanes holding consecutive word addresses within one 64-byte aligned window produce exactly one transaction. That transaction has size 64, the window's base and an all-ones mask.
- R5: Let L be the lowest address among the unserved active lanes. If L's 32-byte aligned window holds exactly one unserved active lane, the next transaction is a single word: `out_size` = 4, `out_base` = L, and the mask holds only that lane.
- R6: Otherwise, the block takes the smallest size from {32, 64, 128, 256} whose L-aligned window holds as many unserved active lanes as L's 256-byte window does. `out_size` gives the size as a byte count, and `out_base` is L rounded down to that size.
- R7: Overhang rule: if the window of the next smaller legal size misses at most one of those lanes, the smaller size is used instead. A lane left over this way is served later, by a single-word transaction of its own.
- R8: Each mask is the set of unserved active lanes whose address lies inside the transaction's window. The masks of a group do not overlap, and together they equal the group's active mask. Every valid transaction has a non-zero mask.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_base`, `out_size` and `out_mask` hold their values.
- R10: `group_done` is high for exactly one cycle. That cycle follows the acceptance of a group's last transaction, and in it `in_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Beat of four lane requests present |
| in_ready | output | 1 | Block is gathering a group |
| in_addr | input | 128 | Four lane byte addresses, lane position p in bits [32p+31:32p] |
| in_active | input | 4 | Active flag per lane position |
| out_valid | output | 1 | Transaction present |
| out_ready | input | 1 | Memory side takes the transaction |
| out_base | output | 32 | Transaction byte base address |
| out_size | output | 9 | Transaction size in bytes (4, 32, 64, 128 or 256) |
| out_mask | output | 16 | Lanes served by this transaction |
| group_done | output | 1 | One-cycle end-of-group pulse |

## Verification
Some properties are checked by the assertions on every cycle: a stalled transaction holds steady, each mask is non-empty and lies inside the unserved set, each size is legal and its base aligned, `in_ready` is mutually exclusive with `out_valid`, and the done pulse lasts one cycle. The choice of transaction size, the overhang split, the single-word case and the union of masks all depend on the whole address pattern. Only the bench's scenarios can show these: aligned sequential runs, shifted runs, wide strides, duplicate addresses, partial and empty active masks, and random clusters. In each, the emitted sequence is compared cycle by cycle against a behavioural model under random back-pressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [0:0] {
      ST_GATHER = 1'b0,
      ST_EMIT   = 1'b1
   } coal_state_t;
endpackage

// File: rtl/coal_gather.sv
// Beat collector: stores lane addresses and active flags of one group.
module coal_gather #(
   parameter int LANES    = 16,
   parameter int LPB      = 4,
   parameter int ADDR_W   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic [LPB*ADDR_W-1:0]   beat_addr,
   input  logic [LPB-1:0]          beat_active,
   output logic [LANES*ADDR_W-1:0] lane_addr,
   output logic [LANES-1:0]        act_full,
   output logic                    last_beat
);
   localparam int BEATS  = LANES / LPB;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   generate
      if (BEATS < 2) begin : g_bad_beats
         $error("coal_gather: at least two beats per group required");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q [LANES];
   logic [LANES-1:0]  act_q;
   logic [BEAT_W-1:0] beat_q;

   assign last_beat = accept && (int'(beat_q) == BEATS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (accept) begin
         beat_q <= last_beat ? '0 : beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         for (int i = 0; i < LANES; i++) addr_q[i] <= '0;
      end else if (accept) begin
         for (int j = 0; j < LPB; j++) begin
            addr_q[int'(beat_q) * LPB + j] <= beat_addr[j*ADDR_W +: ADDR_W];
            act_q[int'(beat_q) * LPB + j]  <= beat_active[j];
         end
      end
   end

   // Active mask including the beat currently being presented.
   always_comb begin
      act_full = act_q;
      for (int j = 0; j < LPB; j++) act_full[int'(beat_q) * LPB + j] = beat_active[j];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_flat
      assign lane_addr[i*ADDR_W +: ADDR_W] = addr_q[i];
   end
endmodule

// File: rtl/coal_window.sv
// Combinational window selector: lowest pending address, per-size
// membership, size choice with overhang shrink and single-word fallback.
module coal_window #(
   parameter int LANES      = 16,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int MIN_LOG2   = 5,
   parameter int MAX_LOG2   = 8,
   parameter int SIZE_W     = MAX_LOG2 + 1
) (
   input  logic [LANES*ADDR_W-1:0] lane_addr,
   input  logic [LANES-1:0]        pend,
   output logic [ADDR_W-1:0]       txn_base,
   output logic [SIZE_W-1:0]       txn_size,
   output logic [LANES-1:0]        txn_mask
);
   localparam int NSZ   = MAX_LOG2 - MIN_LOG2 + 1;
   localparam int CNT_W = $clog2(LANES + 1);

   logic [ADDR_W-1:0] addr [LANES];
   logic [ADDR_W-1:0] low;
   logic [LANES-1:0]  member   [NSZ];
   logic [CNT_W-1:0]  cnt      [NSZ];
   logic [ADDR_W-1:0] win_base [NSZ];
   int                sstar;
   int                pick;

   for (genvar i = 0; i < LANES; i++) begin : g_unflat
      assign addr[i] = lane_addr[i*ADDR_W +: ADDR_W];
   end

   always_comb begin
      low = '1;
      for (int i = 0; i < LANES; i++) begin
         if (pend[i] && addr[i] < low) low = addr[i];
      end
   end

   for (genvar g = 0; g < NSZ; g++) begin : g_level
      localparam int SH = MIN_LOG2 + g;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign member[g][i] = pend[i] && (addr[i][ADDR_W-1:SH] == low[ADDR_W-1:SH]);
      end
      assign cnt[g]      = CNT_W'($countones(member[g]));
      assign win_base[g] = {low[ADDR_W-1:SH], {SH{1'b0}}};
   end

   always_comb begin
      sstar = NSZ - 1;
      for (int g = NSZ - 1; g >= 0; g--) begin
         if (cnt[g] == cnt[NSZ-1]) sstar = g;
      end
      pick = sstar;
      for (int g = 1; g < NSZ; g++) begin
         if (g == sstar && int'(cnt[g-1]) + 1 >= int'(cnt[NSZ-1])) pick = g - 1;
      end
   end

   always_comb begin
      txn_base = low;
      txn_size = SIZE_W'(WORD_BYTES);
      txn_mask = member[0];
      if (cnt[0] != CNT_W'(1)) begin
         for (int g = 0; g < NSZ; g++) begin
            if (g == pick) begin
               txn_base = win_base[g];
               txn_size = SIZE_W'(1) << (MIN_LOG2 + g);
               txn_mask = member[g];
            end
         end
      end
   end
endmodule

// File: rtl/coal_ctrl.sv
// Group sequencer: gather / emit states, pending lane set, done pulse.
module coal_ctrl
   import coal_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last_beat,
   input  logic [LANES-1:0]  act_full,
   input  logic [ADDR_W-1:0] txn_base,
   input  logic [SIZE_W-1:0] txn_size,
   input  logic [LANES-1:0]  txn_mask,
   input  logic              out_ready,
   output logic              gathering,
   output logic              out_valid,
   output logic [LANES-1:0]  pend,
   output logic              group_done
);
   coal_state_t      state_q;
   logic [LANES-1:0] left;

   assign gathering = (state_q == ST_GATHER);
   assign out_valid = (state_q == ST_EMIT);
   assign left      = pend & ~txn_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_GATHER;
         pend       <= '0;
         group_done <= 1'b0;
      end else begin
         group_done <= 1'b0;
         case (state_q)
            ST_GATHER: if (last_beat) begin
               if (act_full == '0) begin
                  group_done <= 1'b1;
               end else begin
                  pend    <= act_full;
                  state_q <= ST_EMIT;
               end
            end
            ST_EMIT: if (out_ready) begin
               pend <= left;
               if (left == '0) begin
                  state_q    <= ST_GATHER;
                  group_done <= 1'b1;
               end
            end
            default: state_q <= ST_GATHER;
         endcase
      end
   end

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(txn_base) && $stable(txn_size)
                                 && $stable(txn_mask)) else $error("stall hold"); // R9
   AST_MASK_INSIDE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (txn_mask != '0) && ((txn_mask & ~pend) == '0)) else $error("mask"); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      group_done |=> !group_done) else $error("done pulse"); // R10
   AST_DONE_THEN_GATHER: assert property (@(posedge clk) disable iff (!rst_n)
      group_done |-> gathering) else $error("done state"); // R10
endmodule

// File: rtl/simd_coalescer.sv
module simd_coalescer #(
   parameter int LANES      = 16,
   parameter int LPB        = 4,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int MIN_LOG2   = 5,
   parameter int MAX_LOG2   = 8,
   localparam int SIZE_W    = MAX_LOG2 + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [LPB*ADDR_W-1:0] in_addr,
   input  logic [LPB-1:0]        in_active,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [ADDR_W-1:0]     out_base,
   output logic [SIZE_W-1:0]     out_size,
   output logic [LANES-1:0]      out_mask,
   output logic                  group_done
);
   generate
      if (LANES % LPB != 0) begin : g_bad_split
         $error("simd_coalescer: LANES must be a multiple of LPB");
      end
      if (MIN_LOG2 > MAX_LOG2 || MAX_LOG2 >= ADDR_W) begin : g_bad_sizes
         $error("simd_coalescer: illegal transaction size range");
      end
      if ((1 << MIN_LOG2) <= WORD_BYTES) begin : g_bad_word
         $error("simd_coalescer: smallest window must exceed one word");
      end
   endgenerate

   logic [LANES*ADDR_W-1:0] lane_addr;
   logic [LANES-1:0]        act_full;
   logic [LANES-1:0]        pend;
   logic                    last_beat;
   logic                    gathering;

   assign in_ready = gathering;

   coal_gather #(.LANES(LANES), .LPB(LPB), .ADDR_W(ADDR_W)) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (in_valid && gathering),
      .beat_addr   (in_addr),
      .beat_active (in_active),
      .lane_addr   (lane_addr),
      .act_full    (act_full),
      .last_beat   (last_beat)
   );

   coal_window #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
                 .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .SIZE_W(SIZE_W)) u_window (
      .lane_addr (lane_addr),
      .pend      (pend),
      .txn_base  (out_base),
      .txn_size  (out_size),
      .txn_mask  (out_mask)
   );

   coal_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .last_beat  (last_beat),
      .act_full   (act_full),
      .txn_base   (out_base),
      .txn_size   (out_size),
      .txn_mask   (out_mask),
      .out_ready  (out_ready),
      .gathering  (gathering),
      .out_valid  (out_valid),
      .pend       (pend),
      .group_done (group_done)
   );

   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid)) else $error("ready overlap"); // R1
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot(out_size) && (out_size == SIZE_W'(WORD_BYTES)
                    || out_size >= (SIZE_W'(1) << MIN_LOG2))) else $error("size"); // R6
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_base & ADDR_W'(out_size - 1'b1)) == '0)) else $error("align"); // R6
endmodule

// File: tb/tb_simd_coalescer.sv
module tb_simd_coalescer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_addr = '0;
   logic [3:0]   in_active = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [31:0]  out_base;
   logic [8:0]   out_size;
   logic [15:0]  out_mask;
   logic         group_done;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   logic [31:0] g_addr [16];
   logic [15:0] g_act;
   logic [31:0] qb [$];
   int          qs [$];
   logic [15:0] qm [$];

   always #4 clk = ~clk;

   simd_coalescer dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_active(in_active), .out_valid(out_valid),
      .out_ready(out_ready), .out_base(out_base), .out_size(out_size),
      .out_mask(out_mask), .group_done(group_done)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural model of the coalescing rules.
   task automatic build_expect();
      logic [15:0] left;
      qb.delete(); qs.delete(); qm.delete();
      left = g_act;
      while (left != 0) begin
         longint lo = 64'hFFFF_FFFF;
         int c [4];
         int sstar, pick, sz;
         logic [15:0] m;
         for (int i = 0; i < 16; i++) if (left[i] && g_addr[i] < lo) lo = g_addr[i];
         for (int k = 0; k < 4; k++) begin
            c[k] = 0;
            for (int i = 0; i < 16; i++)
               if (left[i] && (longint'(g_addr[i]) / (32 << k)) == lo / (32 << k)) c[k]++;
         end
         m = 0;
         if (c[0] == 1) begin
            for (int i = 0; i < 16; i++)
               if (left[i] && (longint'(g_addr[i]) / 32) == lo / 32) m[i] = 1'b1;
            qb.push_back(32'(lo)); qs.push_back(4); qm.push_back(m);
         end else begin
            sstar = 3;
            for (int k = 3; k >= 0; k--) if (c[k] == c[3]) sstar = k;
            pick = sstar;
            if (sstar > 0 && c[sstar-1] >= c[3] - 1) pick = sstar - 1;
            sz = 32 << pick;
            for (int i = 0; i < 16; i++)
               if (left[i] && (longint'(g_addr[i]) / sz) == lo / sz) m[i] = 1'b1;
            qb.push_back(32'((lo / sz) * sz)); qs.push_back(sz); qm.push_back(m);
         end
         left &= ~m;
      end
   endtask

   task automatic run_group(input int exp_count, input string req);
      int beat = 0;
      int fired = 0;
      bit m_emit = 0;
      bit m_done = 0;
      bit acc, fire;
      logic [15:0] uni = 0;
      logic [15:0] ovl = 0;
      build_expect();
      for (int cyc = 0; cyc < 400; cyc++) begin
         @(negedge clk);
         chk(in_ready == !m_emit, "R1", "in_ready", in_ready, !m_emit);
         chk(out_valid == (m_emit && qb.size() > 0), "R8", "out_valid", out_valid, m_emit);
         chk(group_done == m_done, "R10", "group_done", group_done, m_done);
         if (m_done) break;
         if (out_valid && m_emit && qb.size() > 0) begin
            chk(out_base == qb[0], "R6", "out_base", out_base, qb[0]);
            chk(int'(out_size) == qs[0], "R5", "out_size", out_size, qs[0]);
            chk(out_mask == qm[0], "R8", "out_mask", out_mask, qm[0]);
         end
         in_valid  = !m_emit && beat < 4 && ($urandom % 4 != 0);
         for (int j = 0; j < 4; j++) begin
            in_addr[j*32 +: 32] = g_addr[(beat % 4) * 4 + j];
            in_active[j]        = g_act[(beat % 4) * 4 + j];
         end
         out_ready = ($urandom % 3 != 0);
         acc  = in_valid && !m_emit;
         fire = m_emit && out_ready;
         if (fire && out_valid) begin
            fired++;
            ovl |= uni & out_mask;
            uni |= out_mask;
         end
         @(posedge clk);
         m_done = 0;
         if (acc) begin
            beat++;
            if (beat == 4) begin
               if (qb.size() == 0) m_done = 1;
               else m_emit = 1;
            end
         end
         if (fire && qb.size() > 0) begin
            void'(qb.pop_front()); void'(qs.pop_front()); void'(qm.pop_front());
            if (qb.size() == 0) begin
               m_emit = 0;
               m_done = 1;
            end
         end
      end
      in_valid = 1'b0;
      chk(m_done, "R10", "group finished", m_done, 1);
      chk(uni == g_act, "R3", "mask union vs active", uni, g_act);
      chk(ovl == 0, "R8", "mask overlap", ovl, 0);
      if (exp_count >= 0) chk(fired == exp_count, req, "transaction count", fired, exp_count);
   endtask

   initial begin
      #1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", "reset in_ready", in_ready, 1);
      chk(out_valid == 1'b0, "R2", "reset out_valid", out_valid, 0);
      chk(group_done == 1'b0, "R2", "reset group_done", group_done, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: aligned sequential run inside one 64-byte window
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_1000 + 32'(i * 4);
      g_act = 16'hFFFF;
      run_group(1, "R4");

      // R7: run shifted by one word overhangs -> 64 + single word
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_2004 + 32'(i * 4);
      run_group(2, "R7");

      // R7: leading overhang -> single word then 64
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_303C + 32'(i * 4);
      run_group(2, "R7");

      // R5: wide stride -> every lane alone
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_4000 + 32'(i * 256);
      run_group(16, "R5");

      // R3: no active lanes -> no transactions
      g_act = 16'h0000;
      run_group(0, "R3");

      // R3: inactive lanes carry far-away low addresses that must be ignored
      for (int i = 0; i < 16; i++) g_addr[i] = (i % 2 == 0) ? 32'(i * 4) : 32'h0000_5000 + 32'(i * 4);
      g_act = 16'hAAAA;
      run_group(1, "R3");

      // R6: all lanes hit one address (broadcast) -> one 32-byte transaction
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_6010;
      g_act = 16'hFFFF;
      run_group(1, "R6");

      // R6: spread over a 128-byte window -> one 128-byte transaction
      for (int i = 0; i < 16; i++) g_addr[i] = 32'h0000_7000 + 32'(i * 8);
      run_group(1, "R6");

      // R9 and all rules under random clusters and random masks
      for (int n = 0; n < 60; n++) begin
         logic [31:0] region = 32'h0001_0000 + 32'(($urandom % 64) * 256);
         for (int i = 0; i < 16; i++) g_addr[i] = region + 32'(($urandom % 160) * 4);
         g_act = 16'($urandom);
         run_group(-1, "R9");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule